// File: doc/BRIEF.md
# Program Counter and Return-Address Stack

This block keeps the program counter of a small microcontroller core together with its hardware return-address stack. The core's decoder sends it one strobe per kind of control-flow event: a soft restart, interrupt entry, call, jump, the three return flavours (plain return, return-from-interrupt and return-with-literal) and a plain sequential step. Each clock edge the block picks the single event that wins by priority, updates the counter and the stack, and presents the address for the next program-word fetch.

The counter is 13 bits wide and covers an 8K-word logical space, but only a 1K-word program memory is physically present. The fetch address is therefore the low 10 bits of the counter, so any logical address folds back into the physical range. Restart loads word 0000h and interrupt entry loads word 0004h. The stack holds eight return addresses in a circular buffer. It never reports overflow or underflow: a push beyond eight overwrites the oldest entry, and a pop past the bottom reads whichever slot the pointer wraps to. A return-from-interrupt also produces a one-cycle strobe, which outside logic uses to re-enable interrupts globally.

Top module: `pcs_pc_unit`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first event, `pc_o` = 0000h, `fetch_addr_o` = 000h and `gie_reen_o` = 0. The stack pointer and all eight stack slots are cleared to 0.
- R2: When `step_i` is the winning event, `pc_o` becomes the previous value plus 1, modulo 2^13, so 1FFFh steps to 0000h.
- R3: `fetch_addr_o` always equals bits [9:0] of `pc_o`. For example, a counter of 07FFh fetches 3FFh.
- R4: When `jump_i` is the winning event, `pc_o` loads `target_i` and the stack is left unchanged.
- R5: When `call_i` is the winning event, the previous `pc_o` plus 1 (modulo 2^13) is pushed onto the stack and `pc_o` loads `target_i`.
- R6: When `irq_i` is the winning event, the previous `pc_o` is pushed unchanged and `pc_o` loads 0004h.
- R7: When any of `ret_i`, `retie_i` or `retlw_i` is the winning event, the stack pops and `pc_o` loads the popped address. All three behave the same way.
- R8: `gie_reen_o` is high for exactly the one cycle in which `pc_o` shows the value loaded by a winning `retie_i`. It is low at all other times.
- R9: The stack has 8 slots and a pointer that moves modulo 8. A ninth push without a pop overwrites the oldest entry, and a pop from an empty stack returns the slot at the wrapped pointer. No flag is raised in either case.
- R10: Priority, from highest to lowest, is `restart_i`, then `irq_i`, then `call_i`, then `jump_i`, then any return, then `step_i`. Call beats jump when both are high.
- R11: When `restart_i` wins, `pc_o` loads 0000h and the stack pointer returns to slot 0. The stack contents are kept.
- R12: When no strobe is high, `pc_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| restart_i | input | 1 | Soft restart to vector 0000h |
| irq_i | input | 1 | Interrupt entry: push the current counter and go to 0004h |
| call_i | input | 1 | Call: push counter + 1 and load the target |
| jump_i | input | 1 | Jump: load the target without a push |
| ret_i | input | 1 | Plain return (pop) |
| retie_i | input | 1 | Return from interrupt (pop and pulse `gie_reen_o`) |
| retlw_i | input | 1 | Return with literal (pop) |
| step_i | input | 1 | Sequential increment |
| target_i | input | 13 | Jump or call destination |
| pc_o | output | 13 | Logical program counter |
| fetch_addr_o | output | 10 | Physical fetch address |
| gie_reen_o | output | 1 | One-cycle strobe after a return from interrupt |

## Verification
Directed sequences separate the boundary behaviours. A step from 1FFFh tells a 13-bit wrap apart from a wider counter. A counter of 07FFh tells 10-bit folding apart from the full address. Nine nested calls followed by nine returns tell circular overwrite apart from saturating or stalling stacks. A restart placed between calls shows whether the pointer really returns to slot 0. Pairs of simultaneous strobes expose each step of the priority order. A long seeded random stream with every strobe active at once in varied mixes then exercises the whole arbitration and stack pointer together. Each cycle of that stream is compared against an independent behavioural model in the bench.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  // Winning control-flow event for one cycle, after priority resolution
  typedef enum logic [2:0] {
    PCOP_HOLD    = 3'd0,
    PCOP_STEP    = 3'd1,
    PCOP_POP     = 3'd2,
    PCOP_JUMP    = 3'd3,
    PCOP_CALL    = 3'd4,
    PCOP_IRQ     = 3'd5,
    PCOP_RESTART = 3'd6
  } pc_op_e;

  function automatic logic op_pushes(input pc_op_e op);
    return (op == PCOP_CALL) || (op == PCOP_IRQ);
  endfunction

endpackage

// File: rtl/pcs_rst_sync.sv
module pcs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pcs_arbiter.sv
module pcs_arbiter
  import pcs_pkg::*;
(
  input  logic   restart_i,
  input  logic   irq_i,
  input  logic   call_i,
  input  logic   jump_i,
  input  logic   ret_i,
  input  logic   retie_i,
  input  logic   retlw_i,
  input  logic   step_i,
  output pc_op_e op_o,
  output logic   retie_win_o
);

  logic any_pop;

  always_comb begin
    any_pop     = ret_i | retie_i | retlw_i;
    op_o        = PCOP_HOLD;
    retie_win_o = 1'b0;
    if (restart_i)    op_o = PCOP_RESTART;
    else if (irq_i)   op_o = PCOP_IRQ;
    else if (call_i)  op_o = PCOP_CALL;
    else if (jump_i)  op_o = PCOP_JUMP;
    else if (any_pop) begin
      op_o        = PCOP_POP;
      retie_win_o = retie_i;
    end
    else if (step_i)  op_o = PCOP_STEP;
  end

endmodule

// File: rtl/pcs_next_pc.sv
module pcs_next_pc
  import pcs_pkg::*;
#(
  parameter int                PC_W      = 13,
  parameter logic [PC_W-1:0]   RESET_VEC = '0,
  parameter logic [PC_W-1:0]   IRQ_VEC   = 4
) (
  input  pc_op_e          op_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic [PC_W-1:0] target_i,
  input  logic [PC_W-1:0] pop_data_i,
  output logic [PC_W-1:0] pc_next_o,
  output logic [PC_W-1:0] push_data_o
);

  logic [PC_W-1:0] pc_inc;

  always_comb begin
    pc_inc = pc_i + PC_W'(1);
    // Interrupts resume at the interrupted word; calls resume after the call
    push_data_o = (op_i == PCOP_IRQ) ? pc_i : pc_inc;
    unique case (op_i)
      PCOP_RESTART: pc_next_o = RESET_VEC;
      PCOP_IRQ:     pc_next_o = IRQ_VEC;
      PCOP_CALL,
      PCOP_JUMP:    pc_next_o = target_i;
      PCOP_POP:     pc_next_o = pop_data_i;
      PCOP_STEP:    pc_next_o = pc_inc;
      default:      pc_next_o = pc_i;
    endcase
  end

endmodule

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic         clear_ptr_i,
  input  logic [W-1:0] push_data_i,
  output logic [W-1:0] pop_data_o
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [PW-1:0] sp_q, sp_d, sp_inc, sp_dec;
  logic          sp_en;
  logic [W-1:0]  slot_q [DEPTH];

  // Circular pointer arithmetic, valid for any depth
  always_comb begin
    sp_inc = (sp_q == LAST) ? '0 : sp_q + PW'(1);
    sp_dec = (sp_q == '0) ? LAST : sp_q - PW'(1);
    sp_en  = clear_ptr_i | push_i | pop_i;
    if (clear_ptr_i) sp_d = '0;
    else if (push_i) sp_d = sp_inc;
    else if (pop_i)  sp_d = sp_dec;
    else             sp_d = sp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= '0;
    else if (sp_en) sp_q <= sp_d;
  end

  assign pop_data_o = slot_q[sp_dec];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic wr_en;
    assign wr_en = push_i && !clear_ptr_i && (sp_q == PW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     slot_q[g] <= '0;
      else if (wr_en) slot_q[g] <= push_data_i;
    end
  end

endmodule

// File: rtl/pcs_pc_unit.sv
module pcs_pc_unit
  import pcs_pkg::*;
#(
  parameter int PC_W      = 13,
  parameter int FETCH_W   = 10,
  parameter int DEPTH     = 8,
  parameter int RESET_VEC = 0,
  parameter int IRQ_VEC   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart_i,
  input  logic               irq_i,
  input  logic               call_i,
  input  logic               jump_i,
  input  logic               ret_i,
  input  logic               retie_i,
  input  logic               retlw_i,
  input  logic               step_i,
  input  logic [PC_W-1:0]    target_i,
  output logic [PC_W-1:0]    pc_o,
  output logic [FETCH_W-1:0] fetch_addr_o,
  output logic               gie_reen_o
);

  localparam logic [PC_W-1:0] RST_V = PC_W'(RESET_VEC);
  localparam logic [PC_W-1:0] IRQ_V = PC_W'(IRQ_VEC);

  logic            rst_sync_n;
  pc_op_e          op;
  logic            retie_win;
  logic [PC_W-1:0] pc_q, pc_d, push_data, pop_data;
  logic            pc_en;
  logic            reen_q, reen_d;

  pcs_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pcs_arbiter u_arb (
    .restart_i   (restart_i),
    .irq_i       (irq_i),
    .call_i      (call_i),
    .jump_i      (jump_i),
    .ret_i       (ret_i),
    .retie_i     (retie_i),
    .retlw_i     (retlw_i),
    .step_i      (step_i),
    .op_o        (op),
    .retie_win_o (retie_win)
  );

  pcs_next_pc #(.PC_W(PC_W), .RESET_VEC(RST_V), .IRQ_VEC(IRQ_V)) u_nxt (
    .op_i        (op),
    .pc_i        (pc_q),
    .target_i    (target_i),
    .pop_data_i  (pop_data),
    .pc_next_o   (pc_d),
    .push_data_o (push_data)
  );

  pcs_ret_stack #(.DEPTH(DEPTH), .W(PC_W)) u_stk (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .push_i      (op_pushes(op)),
    .pop_i       (op == PCOP_POP),
    .clear_ptr_i (op == PCOP_RESTART),
    .push_data_i (push_data),
    .pop_data_o  (pop_data)
  );

  always_comb begin
    pc_en  = (op != PCOP_HOLD);
    reen_d = retie_win;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) pc_q <= RST_V;
    else if (pc_en)  pc_q <= pc_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) reen_q <= 1'b0;
    else             reen_q <= reen_d;
  end

  assign pc_o         = pc_q;
  assign fetch_addr_o = pc_q[FETCH_W-1:0];
  assign gie_reen_o   = reen_q;

endmodule

// File: rtl/pcs_pc_unit_checker.sv
module pcs_pc_unit_checker #(
  parameter int PC_W      = 13,
  parameter int RESET_VEC = 0,
  parameter int IRQ_VEC   = 4
) (
  input logic            clk,
  input logic            rst_sync_n,
  input logic            restart_i,
  input logic            irq_i,
  input logic            call_i,
  input logic            jump_i,
  input logic            ret_i,
  input logic            retie_i,
  input logic            retlw_i,
  input logic            step_i,
  input logic [PC_W-1:0] target_i,
  input logic [PC_W-1:0] pc_o,
  input logic            gie_reen_o
);

  logic any_ret, none;
  assign any_ret = ret_i | retie_i | retlw_i;
  assign none    = !(restart_i | irq_i | call_i | jump_i | any_ret | step_i);

  AST_RESTART_VEC: assert property (@(posedge clk) disable iff (!rst_sync_n)
    restart_i |=> pc_o == PC_W'(RESET_VEC)); // R11

  AST_IRQ_VEC: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_i && !restart_i) |=> pc_o == PC_W'(IRQ_VEC)); // R6

  AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (jump_i && !call_i && !irq_i && !restart_i) |=> pc_o == $past(target_i)); // R4

  AST_CALL_LOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (call_i && !irq_i && !restart_i) |=> pc_o == $past(target_i)); // R5

  AST_STEP_INC: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step_i && !any_ret && !jump_i && !call_i && !irq_i && !restart_i)
      |=> pc_o == $past(pc_o) + PC_W'(1)); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    none |=> $stable(pc_o)); // R12

  AST_REEN_SOURCE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (retie_i && !jump_i && !call_i && !irq_i && !restart_i) |=> gie_reen_o); // R8

  AST_REEN_ONLY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(retie_i && !jump_i && !call_i && !irq_i && !restart_i) |=> !gie_reen_o); // R8

endmodule

bind pcs_pc_unit pcs_pc_unit_checker #(
  .PC_W(PC_W), .RESET_VEC(RESET_VEC), .IRQ_VEC(IRQ_VEC)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .restart_i  (restart_i),
  .irq_i      (irq_i),
  .call_i     (call_i),
  .jump_i     (jump_i),
  .ret_i      (ret_i),
  .retie_i    (retie_i),
  .retlw_i    (retlw_i),
  .step_i     (step_i),
  .target_i   (target_i),
  .pc_o       (pc_o),
  .gie_reen_o (gie_reen_o)
);

// File: tb/pcs_pc_unit_test.sv
`timescale 1ns/1ps
module pcs_pc_unit_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        restart_i, irq_i, call_i, jump_i, ret_i, retie_i, retlw_i, step_i;
  logic [12:0] target_i;
  logic [12:0] pc_o;
  logic [9:0]  fetch_addr_o;
  logic        gie_reen_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  // Behavioural reference state
  logic [12:0] m_pc;
  logic [2:0]  m_sp;
  logic [12:0] m_stk [8];
  logic        m_reen;

  // Strobe mask bit positions
  localparam int B_RST = 0, B_IRQ = 1, B_CALL = 2, B_JMP = 3;
  localparam int B_RET = 4, B_RTI = 5, B_RLW = 6, B_STEP = 7;

  always #5 clk = ~clk;

  pcs_pc_unit uut (
    .clk(clk), .rst_n(rst_n),
    .restart_i(restart_i), .irq_i(irq_i), .call_i(call_i), .jump_i(jump_i),
    .ret_i(ret_i), .retie_i(retie_i), .retlw_i(retlw_i), .step_i(step_i),
    .target_i(target_i), .pc_o(pc_o), .fetch_addr_o(fetch_addr_o),
    .gie_reen_o(gie_reen_o)
  );

  function automatic string tag_of(input logic [7:0] m);
    if (m[B_RST])  return "R11/R10";
    if (m[B_IRQ])  return "R6/R10";
    if (m[B_CALL]) return "R5/R10";
    if (m[B_JMP])  return "R4/R10";
    if (m[B_RET] | m[B_RTI] | m[B_RLW]) return "R7/R8/R9";
    if (m[B_STEP]) return "R2";
    return "R12";
  endfunction

  // Reference next state, from the requirements' priority list (R10)
  function automatic void model_step(input logic [7:0] m, input logic [12:0] tgt);
    m_reen = 1'b0;
    if (m[B_RST]) begin
      m_pc = 13'h0000; m_sp = 3'd0;
    end else if (m[B_IRQ]) begin
      m_stk[m_sp] = m_pc; m_sp = m_sp + 3'd1; m_pc = 13'h0004;
    end else if (m[B_CALL]) begin
      m_stk[m_sp] = m_pc + 13'd1; m_sp = m_sp + 3'd1; m_pc = tgt;
    end else if (m[B_JMP]) begin
      m_pc = tgt;
    end else if (m[B_RET] | m[B_RTI] | m[B_RLW]) begin
      m_sp = m_sp - 3'd1; m_pc = m_stk[m_sp]; m_reen = m[B_RTI];
    end else if (m[B_STEP]) begin
      m_pc = m_pc + 13'd1;
    end
  endfunction

  task automatic check_out(input string req);
    vectors++;
    if (pc_o !== m_pc || fetch_addr_o !== m_pc[9:0] || gie_reen_o !== m_reen) begin
      errors++;
      $display("FAIL %s: pc=%h fetch=%h reen=%b expected pc=%h fetch=%h reen=%b",
               req, pc_o, fetch_addr_o, gie_reen_o, m_pc, m_pc[9:0], m_reen);
    end
  endtask

  // Drive at the falling edge, let one rising edge act, compare at the next falling edge
  task automatic apply(input logic [7:0] m, input logic [12:0] tgt, input string req);
    {step_i, retlw_i, retie_i, ret_i, jump_i, call_i, irq_i, restart_i} = m;
    target_i = tgt;
    @(posedge clk);
    @(negedge clk);
    model_step(m, tgt);
    check_out(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  m;
    logic [12:0] t;
    void'($urandom(32'h5eed_0c11));
    rst_n = 1'b0;
    {step_i, retlw_i, retie_i, ret_i, jump_i, call_i, irq_i, restart_i} = '0;
    target_i = '0;
    m_pc = '0; m_sp = '0; m_reen = 1'b0;
    for (int i = 0; i < 8; i++) m_stk[i] = '0;
    repeat (3) @(negedge clk);
    check_out("R1 during reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_out("R1 after release");

    // Counter wrap and fetch folding
    apply(8'h08, 13'h1FFF, "R4 jump to top");
    apply(8'h80, 13'h0000, "R2 step wraps to 0");
    apply(8'h08, 13'h07FF, "R3 fetch folds 07FF");
    apply(8'h00, 13'h1234, "R12 idle hold");
    apply(8'h80, 13'h0000, "R3 fetch folds 0800");

    // Nine nested calls, then nine returns: circular overwrite
    for (int i = 0; i < 9; i++) apply(8'h04, 13'(13'h0100 + i * 16), "R9 nested call");
    for (int i = 0; i < 9; i++) apply(8'h10, 13'h0000, "R9 unwind");

    // Interrupt pushes current pc, retie returns there and pulses
    apply(8'h08, 13'h0321, "R4 jump");
    apply(8'h02, 13'h0000, "R6 irq vector");
    apply(8'h80, 13'h0000, "R2 step in handler");
    apply(8'h20, 13'h0000, "R8 retie pulse");
    apply(8'h00, 13'h0000, "R8 pulse ends");
    apply(8'h04, 13'h0050, "R5 call");
    apply(8'h40, 13'h0000, "R7 retlw pops, no pulse");

    // Priority pairs
    apply(8'h03, 13'h0111, "R10 restart over irq");
    apply(8'h06, 13'h0222, "R10 irq over call");
    apply(8'h0C, 13'h0333, "R10 call over jump");
    apply(8'h38, 13'h0444, "R10 jump over returns");
    apply(8'h90, 13'h0000, "R10 return over step");

    // Restart resets pointer, keeps contents
    apply(8'h04, 13'h0AAA, "R5 call");
    apply(8'h04, 13'h0BBB, "R5 call");
    apply(8'h01, 13'h0000, "R11 restart");
    apply(8'h04, 13'h0CCC, "R11 call after restart");
    apply(8'h10, 13'h0000, "R11 return");
    apply(8'h10, 13'h0000, "R11 pop wraps to slot 7");

    // Seeded random mix
    for (int n = 0; n < 4000; n++) begin
      m = '0;
      m[B_RST]  = ($urandom_range(0, 63) == 0);
      m[B_IRQ]  = ($urandom_range(0, 15) == 0);
      m[B_CALL] = ($urandom_range(0, 5) == 0);
      m[B_JMP]  = ($urandom_range(0, 5) == 0);
      m[B_RET]  = ($urandom_range(0, 6) == 0);
      m[B_RTI]  = ($urandom_range(0, 8) == 0);
      m[B_RLW]  = ($urandom_range(0, 8) == 0);
      m[B_STEP] = ($urandom_range(0, 1) == 0);
      t = 13'($urandom);
      apply(m, t, tag_of(m));
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule